// File: doc/BRIEF.md
# Programmable Clock Pattern Channel

This block is one digital pad channel that produces a detector clock waveform by itself. A host loads a 16-bit pattern, a start delay, a bit period and a control word through a small register write port, then arms the channel. When a trigger pulse arrives, the channel waits for the programmed number of master-clock ticks. It then plays the pattern out of the pad most significant bit first, holding each bit for a programmed number of cycles. No further host action is needed once the trigger has been accepted.

The control word selects single or looping play-out, output polarity, the pad mode (output, input or high impedance) and a drive-strength code. The drive-strength code goes straight to the analog pad. Registers written while a play-out is running are kept aside and only take effect at the next trigger, so a host can prepare the next waveform without disturbing the current one. In input mode the pad is released and its level is synchronised into a status output. A busy output marks the whole span from trigger to the end of the last bit.

Register map (2-bit address): 0 = pattern (16 bits), 1 = start delay in ticks (16 bits), 2 = bit period minus one (low 8 bits), 3 = control. Control bits: [0] arm, [1] loop, [2] invert, [4:3] pad mode (00 high-Z, 01 output, 10 input, 11 high-Z), [7:5] drive code.

Top module: `clkpat_channel`

## Requirements
- R1: After reset, busy is 0, pad_oe is 0 (mode high-Z), drive is 0, in_status is 0 and pad_out is 0.
- R2: A trigger sampled high on a clock edge starts a play-out only if control bit 0 (arm) is 1 and the channel is idle; otherwise it has no effect, including a trigger that arrives while busy.
- R3: With start delay D (0 to 65535 ticks), the first pattern bit appears on pad_out D cycles after the edge that accepted the trigger, and pad_out holds the idle level during the delay.
- R4: The pattern plays most significant bit first, each bit held for P+1 cycles, where P is the bit period register value.
- R5: With control bit 2 (invert) set, every pattern bit and the idle level (normally 0) are inverted on pad_out.
- R6: busy is 1 from the accepting edge until the edge that ends the last bit of the final pass.
- R7: With control bit 1 (loop) set, the pattern restarts at its first bit with no gap and no repeated delay; clearing arm stops the play-out at the end of the pass then in progress.
- R8: Register writes made while busy do not change the running play-out (pattern, period, polarity, mode, drive); they take effect at the next trigger.
- R9: pad_oe is 1 only in output mode (control [4:3] = 01); input and both high-Z codes keep it 0.
- R10: In input mode in_status follows pad_in three clock edges after a change; in other modes it holds its last value.
- R11: The drive code (control [7:5]) appears on pad_drive while idle and is frozen while busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 16 | Register write data |
| trig | input | 1 | Start trigger, sampled on each edge |
| pad_in | input | 1 | Level seen at the pad |
| pad_out | output | 1 | Value driven to the pad |
| pad_oe | output | 1 | Pad output enable |
| pad_drive | output | 3 | Drive-strength code to the pad |
| in_status | output | 1 | Synchronised pad level in input mode |
| busy | output | 1 | Play-out in progress |

## Verification
The hardest situation to reach is a register update and a second trigger landing in the middle of a play-out, because the effect must be absent now and present later. The bench writes a new pattern and an inverted, differently configured control word at chosen cycles of a running play-out, pulses the trigger while busy, and checks every cycle of the rest of the pass against the old waveform before triggering again and expecting the new one. Stopping a looping play-out is reached by clearing arm in the middle of the second pass and checking that busy falls exactly at that pass boundary and not earlier.

// File: rtl/clkpat_pkg.sv
// Package for the clock pattern channel: register addresses, control
// bit positions, pad mode codes and sequencer states.
// Assumes a 2-bit register address and a control word of at least 8 bits.
package clkpat_pkg;

    localparam logic [1:0] ADDR_PATTERN = 2'd0;
    localparam logic [1:0] ADDR_DELAY   = 2'd1;
    localparam logic [1:0] ADDR_PERIOD  = 2'd2;
    localparam logic [1:0] ADDR_CTRL    = 2'd3;

    localparam int CTL_ARM    = 0;
    localparam int CTL_LOOP   = 1;
    localparam int CTL_INV    = 2;
    localparam int CTL_MODE_L = 3;
    localparam int CTL_DRV_L  = 5;

    typedef enum logic [1:0] {
        MODE_HIZ  = 2'b00,
        MODE_OUT  = 2'b01,
        MODE_IN   = 2'b10,
        MODE_HIZ2 = 2'b11
    } pad_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_WAIT  = 2'b01,
        ST_SHIFT = 2'b10
    } seq_state_e;

endpackage

// File: rtl/clkpat_regs.sv
// Register file with staging and active copies.
// Writes always land in the staged copy. The active copy follows the
// staged copy while the channel is idle and is frozen while busy, so a
// running play-out never sees a new setting.
// Assumes DATA_W covers the widest field and the 8-bit control layout.
module clkpat_regs
    import clkpat_pkg::*;
#(
    parameter int PAT_W  = 16,
    parameter int DLY_W  = 16,
    parameter int PER_W  = 8,
    parameter int DRV_W  = 3,
    parameter int DATA_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic             busy,
    output logic [PAT_W-1:0] stg_pattern,
    output logic [DLY_W-1:0] stg_delay,
    output logic             stg_arm,
    output logic [PAT_W-1:0] act_pattern,
    output logic [PER_W-1:0] act_period,
    output logic             act_loop,
    output logic             act_invert,
    output logic [1:0]       act_mode,
    output logic [DRV_W-1:0] act_drive
);

    logic [PER_W-1:0] stg_period;
    logic             stg_loop;
    logic             stg_invert;
    logic [1:0]       stg_mode;
    logic [DRV_W-1:0] stg_drive;

    // Capture host writes into the staged register set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_pattern <= '0;
            stg_delay   <= '0;
            stg_period  <= '0;
            stg_arm     <= 1'b0;
            stg_loop    <= 1'b0;
            stg_invert  <= 1'b0;
            stg_mode    <= MODE_HIZ;
            stg_drive   <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_PATTERN: stg_pattern <= wr_data[PAT_W-1:0];
                ADDR_DELAY:   stg_delay   <= wr_data[DLY_W-1:0];
                ADDR_PERIOD:  stg_period  <= wr_data[PER_W-1:0];
                default: begin
                    stg_arm    <= wr_data[CTL_ARM];
                    stg_loop   <= wr_data[CTL_LOOP];
                    stg_invert <= wr_data[CTL_INV];
                    stg_mode   <= wr_data[CTL_MODE_L +: 2];
                    stg_drive  <= wr_data[CTL_DRV_L +: DRV_W];
                end
            endcase
        end
    end

    // Follow the staged set while idle; hold it for the whole play-out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_pattern <= '0;
            act_period  <= '0;
            act_loop    <= 1'b0;
            act_invert  <= 1'b0;
            act_mode    <= MODE_HIZ;
            act_drive   <= '0;
        end else if (!busy) begin
            act_pattern <= stg_pattern;
            act_period  <= stg_period;
            act_loop    <= stg_loop;
            act_invert  <= stg_invert;
            act_mode    <= stg_mode;
            act_drive   <= stg_drive;
        end
    end

endmodule

// File: rtl/clkpat_seq.sv
// Play-out sequencer: start delay counter, bit period timer and pattern
// shifter. A trigger seen on an edge while idle and armed loads the
// pattern; after DLY ticks the bits leave MSB first, each held PER+1
// cycles. Looping reloads from the frozen active pattern while still armed.
// Assumes the active period and loop flag are frozen while busy.
module clkpat_seq
    import clkpat_pkg::*;
#(
    parameter int PAT_W = 16,
    parameter int DLY_W = 16,
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic             stg_arm,
    input  logic [PAT_W-1:0] stg_pattern,
    input  logic [DLY_W-1:0] stg_delay,
    input  logic [PAT_W-1:0] act_pattern,
    input  logic [PER_W-1:0] act_period,
    input  logic             act_loop,
    output logic             busy,
    output logic             shifting,
    output logic             data_bit
);

    localparam int IDX_W = (PAT_W > 1) ? $clog2(PAT_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAT_W - 1);

    seq_state_e       state;
    logic [DLY_W-1:0] dly_cnt;
    logic [PER_W-1:0] bit_tmr;
    logic [IDX_W-1:0] bit_idx;
    logic [PAT_W-1:0] shreg;

    // Advance the delay, bit timer and shifter through one play-out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            dly_cnt <= '0;
            bit_tmr <= '0;
            bit_idx <= '0;
            shreg   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (trig && stg_arm) begin
                        shreg   <= stg_pattern;
                        bit_tmr <= '0;
                        bit_idx <= '0;
                        if (stg_delay == '0) begin
                            state <= ST_SHIFT;
                        end else begin
                            dly_cnt <= stg_delay - 1'b1;
                            state   <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (dly_cnt == '0) begin
                        state <= ST_SHIFT;
                    end else begin
                        dly_cnt <= dly_cnt - 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (bit_tmr == act_period) begin
                        bit_tmr <= '0;
                        if (bit_idx == LAST_IDX) begin
                            if (act_loop && stg_arm) begin
                                shreg   <= act_pattern;
                                bit_idx <= '0;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            shreg   <= shreg << 1;
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end else begin
                        bit_tmr <= bit_tmr + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Expose the sequencer phase and the bit currently on the wire.
    always_comb begin
        busy     = (state != ST_IDLE);
        shifting = (state == ST_SHIFT);
        data_bit = shreg[PAT_W-1];
    end

endmodule

// File: rtl/clkpat_pad.sv
// Pad control: applies polarity to the outgoing bit, derives the output
// enable from the pad mode, passes the drive code through and samples the
// pad level through a synchroniser into a status bit in input mode.
// Assumes the mode and polarity inputs are already frozen while busy.
module clkpat_pad
    import clkpat_pkg::*;
#(
    parameter int DRV_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             invert,
    input  logic             shifting,
    input  logic             data_bit,
    input  logic [DRV_W-1:0] drive,
    input  logic             pad_in,
    output logic             pad_out,
    output logic             pad_oe,
    output logic [DRV_W-1:0] pad_drive,
    output logic             in_status
);

    logic [SYNC_STAGES-1:0] sync_q;

    // Synchroniser chain for the asynchronous pad level.
    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sync_q[i] <= 1'b0;
                end else if (i == 0) begin
                    sync_q[i] <= pad_in;
                end else begin
                    sync_q[i] <= sync_q[(i == 0) ? 0 : i - 1];
                end
            end
        end
    endgenerate

    // Latch the synchronised level only while the pad is an input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_status <= 1'b0;
        end else if (mode == MODE_IN) begin
            in_status <= sync_q[SYNC_STAGES-1];
        end
    end

    // Drive value, enable and strength presented to the pad.
    always_comb begin
        pad_out   = (shifting & data_bit) ^ invert;
        pad_oe    = (mode == MODE_OUT);
        pad_drive = drive;
    end

endmodule

// File: rtl/clkpat_channel.sv
// Top of the programmable clock pattern channel. Joins the register file,
// the play-out sequencer and the pad control. Once a trigger is accepted
// the channel runs with no host involvement.
// Assumes a single clock domain apart from pad_in, which is synchronised.
module clkpat_channel
    import clkpat_pkg::*;
#(
    parameter int PAT_W       = 16,
    parameter int DLY_W       = 16,
    parameter int PER_W       = 8,
    parameter int DRV_W       = 3,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              trig,
    input  logic              pad_in,
    output logic              pad_out,
    output logic              pad_oe,
    output logic [DRV_W-1:0]  pad_drive,
    output logic              in_status,
    output logic              busy
);

    logic [PAT_W-1:0] stg_pattern;
    logic [DLY_W-1:0] stg_delay;
    logic             stg_arm;
    logic [PAT_W-1:0] act_pattern;
    logic [PER_W-1:0] act_period;
    logic             act_loop;
    logic             act_invert;
    logic [1:0]       act_mode;
    logic [DRV_W-1:0] act_drive;
    logic             shifting;
    logic             data_bit;

    clkpat_regs #(
        .PAT_W(PAT_W), .DLY_W(DLY_W), .PER_W(PER_W),
        .DRV_W(DRV_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy),
        .stg_pattern(stg_pattern), .stg_delay(stg_delay), .stg_arm(stg_arm),
        .act_pattern(act_pattern), .act_period(act_period),
        .act_loop(act_loop), .act_invert(act_invert),
        .act_mode(act_mode), .act_drive(act_drive)
    );

    clkpat_seq #(
        .PAT_W(PAT_W), .DLY_W(DLY_W), .PER_W(PER_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .trig(trig),
        .stg_arm(stg_arm), .stg_pattern(stg_pattern), .stg_delay(stg_delay),
        .act_pattern(act_pattern), .act_period(act_period),
        .act_loop(act_loop),
        .busy(busy), .shifting(shifting), .data_bit(data_bit)
    );

    clkpat_pad #(
        .DRV_W(DRV_W), .SYNC_STAGES(SYNC_STAGES)
    ) u_pad (
        .clk(clk), .rst_n(rst_n),
        .mode(act_mode), .invert(act_invert),
        .shifting(shifting), .data_bit(data_bit),
        .drive(act_drive), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_drive(pad_drive), .in_status(in_status)
    );

endmodule

// File: rtl/clkpat_channel_chk.sv
// Checker for the clock pattern channel, bound to the top module.
// Assumes synchronous active-low reset on rst_n.
module clkpat_channel_chk
    import clkpat_pkg::*;
#(
    parameter int PAT_W = 16,
    parameter int DRV_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trig,
    input logic             stg_arm,
    input logic             busy,
    input logic             pad_out,
    input logic             pad_oe,
    input logic             act_invert,
    input logic [1:0]       act_mode,
    input logic [PAT_W-1:0] act_pattern,
    input logic [DRV_W-1:0] pad_drive
);

    // R2: an armed trigger on an idle channel starts a play-out
    a_r2_trig_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && stg_arm && !busy) |=> busy);

    // R2: busy never rises without an accepted trigger
    a_r2_no_spurious_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(trig && stg_arm)) |=> !busy);

    // R3: while idle the pad carries the idle level
    a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (pad_out == act_invert));

    // R8: the running configuration stays frozen through a play-out
    a_r8_frozen_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(act_pattern) && $stable(act_invert)
                                   && $stable(act_mode)));

    // R11: the drive code does not move while busy
    a_r11_drive_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(pad_drive));

    // R9: the pad is enabled only in output mode
    a_r9_oe_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode != MODE_OUT) |-> !pad_oe);

endmodule

bind clkpat_channel clkpat_channel_chk #(.PAT_W(PAT_W), .DRV_W(DRV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .trig(trig), .stg_arm(stg_arm),
    .busy(busy), .pad_out(pad_out), .pad_oe(pad_oe),
    .act_invert(act_invert), .act_mode(act_mode),
    .act_pattern(act_pattern), .pad_drive(pad_drive)
);

// File: tb/clkpat_channel_tb.sv
// Directed bench for the clock pattern channel: one task per scenario.
module clkpat_channel_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        trig = 1'b0;
    logic        pad_in = 1'b0;
    logic        pad_out, pad_oe, in_status, busy;
    logic [2:0]  pad_drive;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    clkpat_channel u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .trig(trig), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_drive(pad_drive),
        .in_status(in_status), .busy(busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] ctl(input bit arm, input bit lp, input bit inv,
                                        input logic [1:0] md, input logic [2:0] drv);
        return {8'd0, drv, md, inv, lp, arm};
    endfunction

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Leaves the bench at the negedge right after the accepting edge (k = 0).
    task automatic pulse_trig();
        @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    function automatic logic exp_out(input logic [15:0] pat, input int d, input int p,
                                     input bit inv, input int k);
        int j;
        if (k < d) return inv;
        j = (k - d) / (p + 1);
        if (j >= 16) return inv;
        return pat[15 - j] ^ inv;
    endfunction

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 pad_oe", pad_oe, 0);
        chk("R1 pad_drive", pad_drive, 0);
        chk("R1 in_status", in_status, 0);
        chk("R1 pad_out", pad_out, 0);
    endtask

    // R3 R4 R5 R6: single play-out checked every cycle
    task automatic t_play(input logic [15:0] pat, input int d, input int p, input bit inv);
        int total;
        wr(2'd0, pat);
        wr(2'd1, 16'(d));
        wr(2'd2, 16'(p));
        wr(2'd3, ctl(1, 0, inv, 2'b01, 3'd2));
        @(negedge clk);
        chk("R5 idle level", pad_out, inv);
        chk("R9 oe in output mode", pad_oe, 1);
        pulse_trig();
        total = d + 16 * (p + 1);
        for (int k = 0; k < total + 3; k++) begin
            chk("R3/R4/R5 pad_out", pad_out, exp_out(pat, d, p, inv, k));
            chk("R6 busy", busy, (k < total) ? 1 : 0);
            @(negedge clk);
        end
    endtask

    // R2: trigger ignored when not armed
    task automatic t_unarmed();
        wr(2'd3, ctl(0, 0, 0, 2'b01, 3'd0));
        @(negedge clk);
        pulse_trig();
        for (int k = 0; k < 5; k++) begin
            chk("R2 unarmed busy", busy, 0);
            chk("R2 unarmed pad_out", pad_out, 0);
            @(negedge clk);
        end
    endtask

    // R7: looping without delay gap, stop at pass end after disarm
    task automatic t_loop();
        logic [15:0] pat = 16'hC5A3;
        int d = 3;
        wr(2'd0, pat);
        wr(2'd1, 16'(d));
        wr(2'd2, 16'd0);
        wr(2'd3, ctl(1, 1, 0, 2'b01, 3'd0));
        @(negedge clk);
        pulse_trig();
        // Disarm is written on the edge after k=20; the pass ending at k=34
        // is the first boundary to see it, so idle from k=35.
        for (int k = 0; k < 40; k++) begin
            logic e;
            if (k < d) e = 1'b0;
            else if (k < 35) e = pat[15 - ((k - d) % 16)];
            else e = 1'b0;
            chk("R7 loop pad_out", pad_out, e);
            chk("R7 loop busy", busy, (k < 35) ? 1 : 0);
            if (k == 20) begin
                wr_en = 1'b1; wr_addr = 2'd3; wr_data = ctl(0, 1, 0, 2'b01, 3'd0);
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    // R8 R2 R11: writes and a second trigger during a play-out
    task automatic t_shadow();
        logic [15:0] pa = 16'hF00D;
        logic [15:0] pb = 16'h1E6B;
        int d = 2, p = 1, total;
        wr(2'd0, pa);
        wr(2'd1, 16'(d));
        wr(2'd2, 16'(p));
        wr(2'd3, ctl(1, 0, 0, 2'b01, 3'd1));
        @(negedge clk);
        pulse_trig();
        total = d + 16 * (p + 1);
        for (int k = 0; k < total; k++) begin
            chk("R8 old pattern kept", pad_out, exp_out(pa, d, p, 0, k));
            chk("R8 busy", busy, 1);
            if (k > 6) chk("R11 drive frozen", pad_drive, 1);
            wr_en = 1'b0; trig = 1'b0;
            if (k == 5) begin wr_en = 1'b1; wr_addr = 2'd0; wr_data = pb; end
            if (k == 6) begin wr_en = 1'b1; wr_addr = 2'd3; wr_data = ctl(1, 0, 1, 2'b01, 3'd6); end
            if (k == 7) trig = 1'b1;  // R2: ignored while busy
            @(negedge clk);
        end
        wr_en = 1'b0;
        chk("R6 done after old pass", busy, 0);
        @(negedge clk);
        chk("R8 new polarity idle", pad_out, 1);
        chk("R11 new drive", pad_drive, 6);
        pulse_trig();
        for (int k = 0; k < total + 2; k++) begin
            chk("R8 new pattern applied", pad_out, exp_out(pb, d, p, 1, k));
            @(negedge clk);
        end
    endtask

    // R9 R10 R11: input and high-Z modes
    task automatic t_modes();
        wr(2'd3, ctl(0, 0, 0, 2'b10, 3'd5));
        @(negedge clk);
        chk("R9 input oe", pad_oe, 0);
        chk("R11 drive pass", pad_drive, 5);
        pad_in = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R10 not yet", in_status, 0);
        @(negedge clk);
        chk("R10 follows high", in_status, 1);
        pad_in = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 follows low", in_status, 0);
        wr(2'd3, ctl(0, 0, 0, 2'b00, 3'd0));
        @(negedge clk);
        chk("R9 hiz oe", pad_oe, 0);
        pad_in = 1'b1;
        repeat (5) @(negedge clk);
        chk("R10 holds in hiz", in_status, 0);
        wr(2'd3, ctl(0, 0, 0, 2'b11, 3'd0));
        @(negedge clk);
        chk("R9 hiz2 oe", pad_oe, 0);
        wr(2'd3, ctl(0, 0, 0, 2'b01, 3'd7));
        @(negedge clk);
        chk("R9 out oe", pad_oe, 1);
        chk("R11 drive 7", pad_drive, 7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_play(16'hA5C3, 0, 0, 0);
        t_play(16'h8001, 4, 2, 0);
        t_play(16'h3C96, 1, 1, 1);
        t_play(16'h7FFE, 1000, 3, 0);
        t_unarmed();
        t_loop();
        t_shadow();
        t_modes();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule